// File: doc/BRIEF.md
# Interrupt Event Status and Enable Register

This block is one 16-bit word in a PHY's management register space. It combines two things. The low byte records link events as sticky flags. The high byte holds one enable per flag, and the enables decide which flags reach a single interrupt pin. A one-cycle pulse on any of the eight event inputs sets its flag. The flag stays set until software reads the word, and the read clears the whole low byte. The enable byte is written through the same address and keeps its value across reads.

Software can use the word in two ways. It can wait on the interrupt pin, or it can poll the word and never use the pin. Flags latch even when their enable is 0, so polling sees every event. The pin's active level comes from a polarity input. That input is driven by a configuration bit that lives in another register.

Top module: `irq_stat_reg`

## Requirements
- R1: After reset, every enable and every status flag is 0. The pin then shows its inactive level: 0 when `pin_act_hi_i` is 1, and 1 when it is 0.
- R2: A pulse on `evt_i[n]` sets status bit n on the next clock edge. The bit stays set until a read, whatever the value of its enable.
- R3: While `rd_en_i` is 1, `rd_data_o` shows the enables in bits 15:8 and the status flags in bits 7:0. The clock edge that ends the read clears all status flags.
- R4: An event that arrives in the same cycle as a read leaves its status bit set after the read, so the next read reports it.
- R5: A write loads `wr_data_i[15:8]` into the enables. `wr_data_i[7:0]` is ignored, so a write can neither set nor clear a status flag.
- R6: The internal interrupt level is the OR, over every bit n, of status bit n AND enable bit 8+n. It follows the registered state combinationally, so it rises in the cycle after the event edge and falls in the cycle after the read edge.
- R7: `irq_o` equals the interrupt level when `pin_act_hi_i` is 1, and its inverse when `pin_act_hi_i` is 0.
- R8: The bits map to events as follows, with status bit n enabled by bit 8+n:
  - bit 7 / enable 15: jabber
  - bit 6 / enable 14: receive error
  - bit 5 / enable 13: page received
  - bit 4 / enable 12: parallel-detect fault
  - bit 3 / enable 11: partner acknowledge
  - bit 2 / enable 10: link status change
  - bit 1 / enable 9: remote fault
  - bit 0 / enable 8: auto-negotiation done
- R9: `rd_data_o` is all zero while `rd_en_i` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| evt_i | input | 8 | Single-cycle event pulses, one per status bit |
| rd_en_i | input | 1 | Read strobe; also clears the status flags |
| wr_en_i | input | 1 | Write strobe |
| wr_data_i | input | 16 | Write data; only bits 15:8 are used |
| rd_data_o | output | 16 | Read data: enables in the high byte, flags in the low byte |
| pin_act_hi_i | input | 1 | Pin polarity: 1 means the pin is active high |
| irq_o | output | 1 | Interrupt pin |

## Verification
The embedded properties check several rules on every cycle:
- an event always produces a set flag one cycle later, including during a read;
- a set flag survives every cycle that has no read;
- a read clears every flag that has no new event;
- the enables change only on a write, and then to the written high byte;
- the pin shows its inactive level whenever no enabled flag is set.

Some behaviour only the bench scenarios can show:
- the exact bit-to-event mapping;
- that status data in a write is ignored;
- that a read returns the value held before it clears;
- the correct interaction of random reads, writes, events and polarity changes against a reference model.

// File: rtl/irq_stat_pkg.sv
package irq_stat_pkg;
    localparam int IRQ_N = 8;

    // Event positions within the status byte
    typedef enum int {
        EV_ANEG_DONE  = 0,
        EV_RMT_FAULT  = 1,
        EV_LINK_CHG   = 2,
        EV_PARTNER_ACK = 3,
        EV_PD_FAULT   = 4,
        EV_PAGE_RX    = 5,
        EV_RX_ERR     = 6,
        EV_JABBER     = 7
    } irq_evt_e;
endpackage

// File: rtl/irq_status_bits.sv
module irq_status_bits #(
    parameter int N = irq_stat_pkg::IRQ_N
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] evt_i,
    input  logic         clr_i,
    output logic [N-1:0] st_o
);
    typedef struct packed {
        logic [N-1:0] flag;
    } st_t;

    st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        for (int i = 0; i < N; i++) begin
            // a new event wins over a clear in the same cycle
            s_d.flag[i] = (s_q.flag[i] & ~clr_i) | evt_i[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign st_o = s_q.flag;

    for (genvar g = 0; g < N; g++) begin : g_chk
        // R4
        evt_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
            evt_i[g] |=> st_o[g]);
        // R2
        sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (st_o[g] && !clr_i) |=> st_o[g]);
        // R3
        read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_i && !evt_i[g]) |=> !st_o[g]);
    end
endmodule

// File: rtl/irq_enable_bits.sv
module irq_enable_bits #(
    parameter int N = irq_stat_pkg::IRQ_N
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en_i,
    input  logic [N-1:0] wr_en_data_i,
    output logic [N-1:0] en_o
);
    typedef struct packed {
        logic [N-1:0] en;
    } en_t;

    en_t e_d, e_q;

    always_comb begin
        e_d = e_q;
        if (wr_en_i) e_d.en = wr_en_data_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) e_q <= '0;
        else        e_q <= e_d;
    end

    assign en_o = e_q.en;

    // R5
    en_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i |=> en_o == $past(wr_en_data_i));
    // R5
    en_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en_i |=> $stable(en_o));
endmodule

// File: rtl/irq_pin_drive.sv
module irq_pin_drive #(
    parameter int N = irq_stat_pkg::IRQ_N
) (
    input  logic [N-1:0] st_i,
    input  logic [N-1:0] en_i,
    input  logic         act_hi_i,
    output logic         irq_o
);
    logic [N-1:0] hit;
    logic         level;

    for (genvar g = 0; g < N; g++) begin : g_hit
        assign hit[g] = st_i[g] & en_i[g];
    end

    always_comb begin
        level = |hit;
        irq_o = act_hi_i ? level : ~level;
    end
endmodule

// File: rtl/irq_stat_reg.sv
module irq_stat_reg #(
    parameter int N = irq_stat_pkg::IRQ_N,
    localparam int W = 2 * N
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] evt_i,
    input  logic         rd_en_i,
    input  logic         wr_en_i,
    input  logic [W-1:0] wr_data_i,
    output logic [W-1:0] rd_data_o,
    input  logic         pin_act_hi_i,
    output logic         irq_o
);
    logic [N-1:0] st;
    logic [N-1:0] en;

    irq_status_bits #(.N(N)) u_st (
        .clk   (clk),
        .rst_n (rst_n),
        .evt_i (evt_i),
        .clr_i (rd_en_i),
        .st_o  (st)
    );

    irq_enable_bits #(.N(N)) u_en (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en_i      (wr_en_i),
        .wr_en_data_i (wr_data_i[W-1:N]),
        .en_o         (en)
    );

    irq_pin_drive #(.N(N)) u_pin (
        .st_i     (st),
        .en_i     (en),
        .act_hi_i (pin_act_hi_i),
        .irq_o    (irq_o)
    );

    always_comb begin
        rd_data_o = '0;
        if (rd_en_i) rd_data_o = {en, st};
    end

    // R7
    idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((st & en) == '0) |-> (irq_o == !pin_act_hi_i));
    // R9
    quiet_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en_i |-> (rd_data_o == '0));
endmodule

// File: tb/sim_irq_stat_reg.sv
module sim_irq_stat_reg;
    import irq_stat_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  evt = '0;
    logic        rd = 1'b0;
    logic        wr = 1'b0;
    logic [15:0] wd = '0;
    logic [15:0] rdata;
    logic        pol = 1'b1;
    logic        irq;

    int checks = 0;
    int errors = 0;

    logic [7:0] m_st = '0;
    logic [7:0] m_en = '0;

    always #10 clk = ~clk;

    irq_stat_reg u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .evt_i        (evt),
        .rd_en_i      (rd),
        .wr_en_i      (wr),
        .wr_data_i    (wd),
        .rd_data_o    (rdata),
        .pin_act_hi_i (pol),
        .irq_o        (irq)
    );

    function automatic logic exp_irq(logic [7:0] s, logic [7:0] e, logic p);
        logic lvl;
        lvl = |(s & e);
        return p ? lvl : ~lvl;
    endfunction

    function automatic logic [15:0] exp_rd(logic r, logic [7:0] s, logic [7:0] e);
        return r ? {e, s} : 16'h0000;
    endfunction

    task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One cycle: drive at the falling edge, check before the rising edge,
    // then advance the reference model
    task automatic step(logic [7:0] e, logic r, logic w, logic [15:0] d, logic p);
        @(negedge clk);
        evt = e; rd = r; wr = w; wd = d; pol = p;
        #1;
        chk("R6 R7 irq", {15'h0, irq}, {15'h0, exp_irq(m_st, m_en, p)});
        chk("R3 R9 rd_data", rdata, exp_rd(r, m_st, m_en));
        @(posedge clk);
        m_st = (r ? 8'h00 : m_st) | e;
        if (w) m_en = d[15:8];
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        // R1: reset state, both polarities
        rd = 1'b1;
        #3;
        chk("R1 rd", rdata, 16'h0000);
        chk("R1 irq hi", {15'h0, irq}, 16'h0000);
        pol = 1'b0;
        #1;
        chk("R1 irq lo", {15'h0, irq}, 16'h0001);
        rd = 1'b0; pol = 1'b1;
        @(negedge clk);
        rst_n = 1'b1;

        // R8: jabber is bit 7, enabled by bit 15 only
        step(8'h00, 0, 1, 16'h0100, 1);
        step(8'h01 << EV_JABBER, 0, 0, 16'h0, 1);
        step(8'h00, 0, 0, 16'h0, 1);   // R8 flag set but bit 8 does not enable it: irq low
        step(8'h00, 0, 1, 16'h8000, 1);
        step(8'h00, 0, 0, 16'h0, 1);   // R8 bit 15 enables it: irq high
        step(8'h00, 1, 0, 16'h0, 1);   // R3 read returns 8080 and clears

        // R5: status bits in write data ignored
        step(8'h00, 0, 1, 16'h55FF, 1);
        step(8'h00, 1, 0, 16'h0, 1);   // R5 expects 5500

        // R4: event in a read cycle survives
        step(8'h01 << EV_LINK_CHG, 1, 0, 16'h0, 1);
        step(8'h00, 1, 0, 16'h0, 1);   // R4 expects bit 2 still set

        // R2: latch with enables off, polling sees it
        step(8'h00, 0, 1, 16'h0000, 0);
        step(8'h01 << EV_RX_ERR, 0, 0, 16'h0, 0);
        step(8'h00, 0, 0, 16'h0, 0);
        step(8'h00, 1, 0, 16'h0, 0);   // R2 expects 0040

        // random mix
        for (int i = 0; i < 3000; i++) begin
            logic [7:0] e;
            e = (($urandom % 4) == 0) ? 8'($urandom) & 8'($urandom) : 8'h00;
            step(e, ($urandom % 4) == 0, ($urandom % 8) == 0, 16'($urandom),
                 ($urandom % 16) != 0);
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule